// File: doc/BRIEF.md
# Erased Sector Zero-Bit Detector

This block sits behind a sector decoder. It decides whether a sector that the decoder could not correct is really a freshly erased sector. Such a sector is all ones, and its stored check bytes are all ones too, so they do not match the code of an all-ones payload. When the decoder reports more errors than the correction limit, the block streams the sector's payload bytes and stored check bytes. It keeps one zero-bit count for each region, and each count saturates just above the limit.

The block gives one of two verdicts on a one-cycle `done` pulse. In the erased case, the sector is accepted as all ones, the total number of zero bits is reported, and a flag asks for the payload to be overwritten with ones when any payload bit was zero. In the uncorrectable case, the sector is not an erased page. Clearing the payload memory is left to the consumer.

Top module: `erased_sector_detector`

## Requirements
- R1: After reset, `done`, `erased`, `uncorrectable`, `force_ones` and `zero_total` are all 0.
- R2: A `sec_start` pulse arms the check only when the sampled `dec_errs` is greater than LIMIT (8). If the check is not armed, the matching `sec_end` gives no `done` pulse.
- R3: Each byte with `byte_vld` high adds the number of zero bits in `byte_in`, which is the popcount of the inverted byte. The byte counts toward the check region when `byte_is_ecc` is 1 and toward the payload region when it is 0. A byte on the `sec_start` cycle is not counted.
- R4: The two regions keep separate counts. Each count stops growing once it exceeds LIMIT and holds at LIMIT+1.
- R5: When the payload count plus the check count is at most LIMIT, the verdict is erased (`erased`=1, `uncorrectable`=0) and `zero_total` equals that sum.
- R6: In the erased verdict, `force_ones` is 1 exactly when the payload count is nonzero.
- R7: When the sum exceeds LIMIT, the verdict is uncorrectable (`uncorrectable`=1, `erased`=0), with `force_ones`=0 and `zero_total`=0.
- R8: `done` is high for one cycle, in the cycle after the clock edge that samples `sec_end`. A byte presented together with `sec_end` is counted. All verdict outputs are 0 whenever `done` is 0.
- R9: `sec_start` clears both counts, so a restart in the middle of a sector discards the earlier bytes.
- R10: After a verdict the block is disarmed, and a further `sec_end` without a new arming `sec_start` gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_start | input | 1 | Sector start strobe; clears counts and samples `dec_errs` |
| dec_errs | input | 4 | Error count reported by the decoder |
| byte_vld | input | 1 | `byte_in` holds a sector byte this cycle |
| byte_is_ecc | input | 1 | 1 = stored check byte, 0 = payload byte |
| byte_in | input | 8 | Sector byte |
| sec_end | input | 1 | Sector end strobe |
| done | output | 1 | One-cycle verdict pulse |
| erased | output | 1 | Verdict: erased sector |
| uncorrectable | output | 1 | Verdict: not an erased page |
| force_ones | output | 1 | Payload must be overwritten with all ones |
| zero_total | output | 5 | Zero bits found (erased verdict only) |

## Verification
The hardest case to reach is saturation: a region count that passes the limit and must then hold, while the other region is still counting, and without the verdict wrapping back to erased. The stimulus puts many single-zero bytes into one region (20 payload zeros, and 13 check zeros), so the count passes LIMIT well before the region ends. A fully zero byte and a byte that arrives on the end strobe test the count steps at the edges. A restart in the middle of a sector tests that start clears the counts.

// File: rtl/esd_pkg.sv
package esd_pkg;

    typedef enum logic [1:0] {
        VERD_NONE   = 2'd0,
        VERD_ERASED = 2'd1,
        VERD_BAD    = 2'd2
    } verdict_e;

    typedef struct packed {
        verdict_e verdict;
        logic     force_ones;
    } verdict_t;

    localparam int unsigned REGION_DATA = 0;
    localparam int unsigned REGION_ECC  = 1;
    localparam int unsigned NUM_REGIONS = 2;

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/esd_zero_count.sv
module esd_zero_count #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OUT_W  = 4
) (
    input  logic [BYTE_W-1:0] data_i,
    output logic [OUT_W-1:0]  zeros_o
);
    always_comb begin
        zeros_o = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            zeros_o = zeros_o + OUT_W'(!data_i[i]);
        end
    end
endmodule

// File: rtl/esd_sat_counter.sv
module esd_sat_counter #(
    parameter int unsigned IN_W  = 4,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc_en,
    input  logic [IN_W-1:0]  inc,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] next_o
);
    localparam int unsigned ACC_W = esd_pkg::max_u(CNT_W, IN_W) + 1;
    localparam logic [ACC_W-1:0] SAT_ACC = ACC_W'(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(cnt_q) + ACC_W'(inc);
        if (clear) begin
            next_o = '0;
        end else if (inc_en) begin
            next_o = (acc > SAT_ACC) ? CNT_W'(SAT_ACC) : CNT_W'(acc);
        end else begin
            next_o = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= next_o;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/esd_verdict.sv
module esd_verdict
    import esd_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned TOT_W = 5,
    parameter int unsigned LIMIT = 8
) (
    input  logic [CNT_W-1:0] data_cnt,
    input  logic [CNT_W-1:0] ecc_cnt,
    output verdict_t         verdict_o,
    output logic [TOT_W-1:0] total_o
);
    logic [TOT_W-1:0] sum;

    always_comb begin
        sum = TOT_W'(data_cnt) + TOT_W'(ecc_cnt);
        if (sum <= TOT_W'(LIMIT)) begin
            verdict_o.verdict    = VERD_ERASED;
            verdict_o.force_ones = (data_cnt != '0);
            total_o              = sum;
        end else begin
            verdict_o.verdict    = VERD_BAD;
            verdict_o.force_ones = 1'b0;
            total_o              = '0;
        end
    end
endmodule

// File: rtl/erased_sector_detector.sv
module erased_sector_detector
    import esd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LIMIT  = 8,
    parameter int unsigned ERR_W  = 4,
    parameter int unsigned TOT_W  = $clog2(LIMIT + 2) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_start,
    input  logic [ERR_W-1:0]  dec_errs,
    input  logic              byte_vld,
    input  logic              byte_is_ecc,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              sec_end,
    output logic              done,
    output logic              erased,
    output logic              uncorrectable,
    output logic              force_ones,
    output logic [TOT_W-1:0]  zero_total
);
    localparam int unsigned POP_W = $clog2(BYTE_W + 1);
    localparam int unsigned CNT_W = $clog2(LIMIT + 2);

    logic             armed_q;
    logic [POP_W-1:0] byte_zeros;
    logic [CNT_W-1:0] cnt_q    [NUM_REGIONS];
    logic [CNT_W-1:0] cnt_next [NUM_REGIONS];
    logic             count_ok;
    logic             finish;
    verdict_t         verdict;
    logic [TOT_W-1:0] total;

    esd_zero_count #(.BYTE_W(BYTE_W), .OUT_W(POP_W)) u_zeros (
        .data_i  (byte_in),
        .zeros_o (byte_zeros)
    );

    assign count_ok = armed_q && byte_vld && !sec_start;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic sel;
        assign sel = (g == REGION_ECC) ? byte_is_ecc : !byte_is_ecc;
        esd_sat_counter #(.IN_W(POP_W), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clear   (sec_start),
            .inc_en  (count_ok && sel),
            .inc     (byte_zeros),
            .count_o (cnt_q[g]),
            .next_o  (cnt_next[g])
        );
    end

    esd_verdict #(.CNT_W(CNT_W), .TOT_W(TOT_W), .LIMIT(LIMIT)) u_verdict (
        .data_cnt  (cnt_next[REGION_DATA]),
        .ecc_cnt   (cnt_next[REGION_ECC]),
        .verdict_o (verdict),
        .total_o   (total)
    );

    assign finish = armed_q && sec_end && !sec_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q       <= 1'b0;
            done          <= 1'b0;
            erased        <= 1'b0;
            uncorrectable <= 1'b0;
            force_ones    <= 1'b0;
            zero_total    <= '0;
        end else begin
            done          <= finish;
            erased        <= finish && (verdict.verdict == VERD_ERASED);
            uncorrectable <= finish && (verdict.verdict == VERD_BAD);
            force_ones    <= finish && verdict.force_ones;
            zero_total    <= finish ? total : '0;
            if (sec_start)   armed_q <= (dec_errs > ERR_W'(LIMIT));
            else if (finish) armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/esd_checker.sv
module esd_checker #(
    parameter int unsigned LIMIT = 8,
    parameter int unsigned TOT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_end,
    input logic             done,
    input logic             erased,
    input logic             uncorrectable,
    input logic             force_ones,
    input logic [TOT_W-1:0] zero_total
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_follows_end_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(sec_end));

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!erased && !uncorrectable && !force_ones && zero_total == '0));

    assert_one_verdict_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({erased, uncorrectable}) == 1));

    assert_erased_bound_R5: assert property (@(posedge clk) disable iff (rst)
        erased |-> (zero_total <= TOT_W'(LIMIT)));

    assert_force_needs_erased_R6: assert property (@(posedge clk) disable iff (rst)
        force_ones |-> erased);

    assert_bad_clean_R7: assert property (@(posedge clk) disable iff (rst)
        uncorrectable |-> (!force_ones && zero_total == '0));
endmodule

bind erased_sector_detector esd_checker #(.LIMIT(LIMIT), .TOT_W(TOT_W)) u_esd_checker (
    .clk           (clk),
    .rst           (rst),
    .sec_end       (sec_end),
    .done          (done),
    .erased        (erased),
    .uncorrectable (uncorrectable),
    .force_ones    (force_ones),
    .zero_total    (zero_total)
);

// File: tb/erased_sector_detector_test.sv
module erased_sector_detector_test;
    localparam int LIMIT = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       sec_start, byte_vld, byte_is_ecc, sec_end;
    logic [3:0] dec_errs;
    logic [7:0] byte_in;
    logic       done, erased, uncorrectable, force_ones;
    logic [4:0] zero_total;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    erased_sector_detector uut (
        .clk(clk), .rst(rst), .sec_start(sec_start), .dec_errs(dec_errs),
        .byte_vld(byte_vld), .byte_is_ecc(byte_is_ecc), .byte_in(byte_in),
        .sec_end(sec_end), .done(done), .erased(erased),
        .uncorrectable(uncorrectable), .force_ones(force_ones),
        .zero_total(zero_total)
    );

    typedef struct packed {
        logic [3:0] errs;
        logic [7:0] dz;
        logic [7:0] ez;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd9,  8'd0,  8'd0},
        '{4'd9,  8'd3,  8'd0},
        '{4'd9,  8'd0,  8'd5},
        '{4'd12, 8'd4,  8'd4},
        '{4'd15, 8'd5,  8'd4},
        '{4'd9,  8'd20, 8'd0},
        '{4'd9,  8'd0,  8'd13},
        '{4'd8,  8'd0,  8'd0},
        '{4'd0,  8'd3,  8'd2},
        '{4'd10, 8'd0,  8'd8}
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sec_start = 0; byte_vld = 0; byte_is_ecc = 0; sec_end = 0;
        dec_errs = 0; byte_in = 8'hFF;
    endtask

    task automatic start(input logic [3:0] errs);
        sec_start = 1; dec_errs = errs;
        @(negedge clk);
        sec_start = 0;
    endtask

    task automatic send(input logic [7:0] b, input logic ecc);
        byte_vld = 1; byte_in = b; byte_is_ecc = ecc;
        @(negedge clk);
        byte_vld = 0;
    endtask

    task automatic finish_sector();
        sec_end = 1;
        @(negedge clk);
        sec_end = 0; byte_vld = 0;
    endtask

    task automatic expect_verdict(string req, int e_done, int e_er, int e_force, int e_tot);
        chk({req, " done"}, done, e_done);
        chk({req, " erased"}, erased, e_er);
        chk({req, " uncorrectable"}, uncorrectable, e_done && !e_er);
        chk({req, " force_ones"}, force_ones, e_force);
        chk({req, " zero_total"}, zero_total, e_tot);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        expect_verdict("R1", 0, 0, 0, 0);

        // Vector table: R2 R3 R4 R5 R6 R7
        foreach (VECS[k]) begin
            automatic int dz = VECS[k].dz;
            automatic int ez = VECS[k].ez;
            automatic int e_done = (VECS[k].errs > LIMIT);
            automatic int dsat = (dz > LIMIT) ? LIMIT + 1 : dz;
            automatic int esat = (ez > LIMIT) ? LIMIT + 1 : ez;
            automatic int e_er = e_done && (dsat + esat <= LIMIT);
            start(VECS[k].errs);
            for (int i = 0; i < 512; i++) send((i < dz) ? 8'hFE : 8'hFF, 1'b0);
            for (int i = 0; i < 13; i++)  send((i < ez) ? 8'hEF : 8'hFF, 1'b1);
            finish_sector();
            expect_verdict($sformatf("R2/R5/R6/R7 vec%0d", k), e_done, e_er,
                           e_er && (dz != 0), e_er ? dz + ez : 0);
            @(negedge clk);
            // R8 pulse lasts one cycle
            chk("R8 done single", done, 0);
        end

        // R3: fully zero payload byte counts 8 -> erased, total 8
        start(4'd9);
        send(8'h00, 1'b0);
        finish_sector();
        expect_verdict("R3 full zero byte", 1, 1, 1, 8);

        // R3: mixed byte in check region, 0x5A has 4 zeros, plus 0x0F 4 zeros
        start(4'd9);
        send(8'h5A, 1'b1);
        send(8'h0F, 1'b1);
        finish_sector();
        expect_verdict("R3 check region popcount", 1, 1, 0, 8);

        // R4: one more zero bit past the limit -> uncorrectable
        start(4'd9);
        send(8'h00, 1'b0);
        send(8'hFE, 1'b1);
        finish_sector();
        expect_verdict("R4 limit plus one", 1, 0, 0, 0);

        // R8: byte presented with sec_end is counted
        start(4'd9);
        byte_vld = 1; byte_in = 8'hFC; byte_is_ecc = 0;
        finish_sector();
        expect_verdict("R8 byte on end strobe", 1, 1, 1, 2);

        // R9: restart discards earlier bytes
        start(4'd9);
        for (int i = 0; i < 6; i++) send(8'hFE, 1'b0);
        start(4'd9);
        send(8'hF0, 1'b1);
        finish_sector();
        expect_verdict("R9 restart clears", 1, 1, 0, 4);

        // R3: byte on the start cycle is not counted
        byte_vld = 1; byte_in = 8'h00; byte_is_ecc = 0;
        start(4'd9);
        byte_vld = 0;
        finish_sector();
        expect_verdict("R3 start-cycle byte", 1, 1, 0, 0);

        // R10: second end strobe after verdict gives no done
        send(8'h00, 1'b0);
        finish_sector();
        expect_verdict("R10 disarmed", 0, 0, 0, 0);

        // R2: not armed at threshold, bytes and end give nothing
        start(4'd8);
        send(8'h00, 1'b0);
        finish_sector();
        expect_verdict("R2 threshold not armed", 0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule